// File: doc/BRIEF.md
# Processor Status Register with Global Interrupt Gate

An eight-bit status register for a small processor core. One part of it holds the arithmetic condition flags, which the ALU writes. Each flag has its own update enable, so an operation rewrites only the flags it defines. The sign flag is never taken from the ALU. It is kept equal to the exclusive-or of the negative and overflow flags.

The top bit is the global interrupt enable. The ALU cannot touch it. Dedicated commands set and clear it. A taken interrupt clears it, and a return-from-interrupt command sets it again.

The block also gates the core's pending-interrupt request into a take signal. That signal is asserted only while the enable bit is 1, and it is suppressed in the same cycle that a clear command arrives. A full-register load path, used for restoring a saved status word, overrides every other update.

Top module: `status_reg_gate`

## Requirements
- R1: While rst_ni is low the register reads 8'h00, so interrupts start disabled. irq_take_o stays 0 even with irq_pend_i high.
- R2: The bit layout from bit 7 down to bit 0 is enable (I), T, H, S, V, N, Z, C. alu_we_i and alu_val_i use the same bit positions. For bits 6, 5, 3, 2, 1 and 0, a set enable bit loads the value bit at the next clock edge, and a clear enable bit holds the old value.
- R3: Bit 4 (S) comes from the flags, not from the ALU. After a cycle in which alu_we_i[3] or alu_we_i[2] is set, S equals the new N XOR the new V; otherwise S holds. alu_we_i[4] and alu_val_i[4] are ignored.
- R4: The ALU path never changes bit 7. alu_we_i[7] and alu_val_i[7] are ignored.
- R5: irq_take_o is combinational and equals irq_pend_i AND bit 7 AND NOT ie_clr_i. While bit 7 is 0, no interrupt is taken.
- R6: ie_clr_i suppresses irq_take_o in the same cycle and clears bit 7 at the next edge. It wins over ie_set_i and irq_ret_i.
- R7: ie_set_i or irq_ret_i sets bit 7 at the next edge. A request that was already pending is taken from that cycle on.
- R8: A cycle with irq_take_o high clears bit 7 at the next edge. This wins over set and return.
- R9: ld_en_i writes ld_val_i into all eight bits at the next edge, overriding the ALU, the enable commands and the clear caused by a take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alu_we_i | input | 8 | Per-flag update enables from the ALU (bits 7 and 4 ignored) |
| alu_val_i | input | 8 | Per-flag values from the ALU (bits 7 and 4 ignored) |
| ie_set_i | input | 1 | Set the interrupt enable bit |
| ie_clr_i | input | 1 | Clear the interrupt enable bit, blocking takes at once |
| irq_ret_i | input | 1 | Return from interrupt: set the enable bit |
| ld_en_i | input | 1 | Full-register load strobe |
| ld_val_i | input | 8 | Full-register load value |
| irq_pend_i | input | 1 | Pending interrupt request |
| sreg_o | output | 8 | Register value |
| irq_take_o | output | 1 | Gated interrupt take |

## Verification
The flag path is swept over all 256 enable masks, each with 16 value patterns and 16 starting words. This separates flags that must follow their enable from flags that must hold, and it shows S tracking N XOR V only when N or V moves. Because the masks include bits 7 and 4, the same sweep shows that the ALU never reaches the enable bit or the raw sign input.

The interrupt path is tried with all 128 combinations of starting enable state, pending, set, clear, return, load and loaded enable bit. During these cycles the ALU writes every flag. The combinations separate same-cycle suppression by clear from the one-cycle delay of set, and the self-clear after a take from the load override. The cycle after each combination shows whether a request still pending is then taken.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int SREG_W = 8;
  localparam int BIT_I  = 7;
  localparam int BIT_T  = 6;
  localparam int BIT_H  = 5;
  localparam int BIT_S  = 4;
  localparam int BIT_V  = 3;
  localparam int BIT_N  = 2;
  localparam int BIT_Z  = 1;
  localparam int BIT_C  = 0;
  typedef logic [SREG_W-1:0] sreg_t;
endpackage

// File: rtl/sreg_flag_merge.sv
module sreg_flag_merge
  import sreg_pkg::*;
(
  input  sreg_t cur_i,
  input  sreg_t we_i,
  input  sreg_t val_i,
  output sreg_t nxt_o
);
  logic n_new, v_new, nv_upd;
  assign n_new  = we_i[BIT_N] ? val_i[BIT_N] : cur_i[BIT_N];
  assign v_new  = we_i[BIT_V] ? val_i[BIT_V] : cur_i[BIT_V];
  assign nv_upd = we_i[BIT_N] | we_i[BIT_V];

  // raw ALU inputs on the I and S positions have no path
  logic unused_alu_bits;
  assign unused_alu_bits = ^{we_i[BIT_I], we_i[BIT_S], val_i[BIT_I], val_i[BIT_S]};

  for (genvar b = 0; b < SREG_W; b++) begin : g_bit
    if (b == BIT_I) begin : g_ie
      assign nxt_o[b] = cur_i[b];
    end else if (b == BIT_S) begin : g_sign
      assign nxt_o[b] = nv_upd ? (n_new ^ v_new) : cur_i[b];
    end else begin : g_flag
      assign nxt_o[b] = we_i[b] ? val_i[b] : cur_i[b];
    end
  end
endmodule

// File: rtl/sreg_ie_ctrl.sv
module sreg_ie_ctrl (
  input  logic ie_q_i,
  input  logic pend_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic ret_i,
  output logic take_o,
  output logic ie_nxt_o
);
  // clear blocks in the same cycle; set only opens from the next one
  assign take_o = pend_i & ie_q_i & ~clr_i;

  always_comb begin
    if (take_o || clr_i)     ie_nxt_o = 1'b0;
    else if (set_i || ret_i) ie_nxt_o = 1'b1;
    else                     ie_nxt_o = ie_q_i;
  end
endmodule

// File: rtl/status_reg_gate.sv
module status_reg_gate
  import sreg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SREG_W-1:0] alu_we_i,
  input  logic [SREG_W-1:0] alu_val_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic              irq_ret_i,
  input  logic              ld_en_i,
  input  logic [SREG_W-1:0] ld_val_i,
  input  logic              irq_pend_i,
  output logic [SREG_W-1:0] sreg_o,
  output logic              irq_take_o
);
  sreg_t sreg_q, arith_nxt, merged_nxt;
  logic  ie_nxt;

  sreg_flag_merge u_flags (
    .cur_i (sreg_q),
    .we_i  (alu_we_i),
    .val_i (alu_val_i),
    .nxt_o (arith_nxt)
  );

  sreg_ie_ctrl u_ie (
    .ie_q_i   (sreg_q[BIT_I]),
    .pend_i   (irq_pend_i),
    .set_i    (ie_set_i),
    .clr_i    (ie_clr_i),
    .ret_i    (irq_ret_i),
    .take_o   (irq_take_o),
    .ie_nxt_o (ie_nxt)
  );

  always_comb begin
    merged_nxt        = arith_nxt;
    merged_nxt[BIT_I] = ie_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (ld_en_i) sreg_q <= ld_val_i;
    else              sreg_q <= merged_nxt;
  end

  assign sreg_o = sreg_q;
endmodule

// File: rtl/status_reg_gate_chk.sv
module status_reg_gate_chk
  import sreg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SREG_W-1:0] alu_we_i,
  input logic              ie_set_i,
  input logic              ie_clr_i,
  input logic              irq_ret_i,
  input logic              ld_en_i,
  input logic [SREG_W-1:0] ld_val_i,
  input logic              irq_pend_i,
  input logic [SREG_W-1:0] sreg_o,
  input logic              irq_take_o
);
  // R5
  take_needs_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (sreg_o[BIT_I] && irq_pend_i));

  // R6
  clr_blocks_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ie_clr_i |-> !irq_take_o);

  // R6
  clr_drops_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_clr_i && !ld_en_i) |=> !sreg_o[BIT_I]);

  // R8
  take_drops_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_take_o && !ld_en_i) |=> !sreg_o[BIT_I]);

  // R7
  set_raises_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ie_set_i || irq_ret_i) && !ie_clr_i && !irq_take_o && !ld_en_i) |=> sreg_o[BIT_I]);

  // R4
  ie_quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_en_i && !ie_set_i && !ie_clr_i && !irq_ret_i && !irq_take_o)
      |=> (sreg_o[BIT_I] == $past(sreg_o[BIT_I])));

  // R3
  sign_tracks_nv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_en_i && (alu_we_i[BIT_N] || alu_we_i[BIT_V]))
      |=> (sreg_o[BIT_S] == (sreg_o[BIT_N] ^ sreg_o[BIT_V])));

  // R9
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i |=> (sreg_o == $past(ld_val_i)));

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_clear_chk: assert (sreg_o == '0 && !irq_take_o);
    end
  end
endmodule

bind status_reg_gate status_reg_gate_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .alu_we_i   (alu_we_i),
  .ie_set_i   (ie_set_i),
  .ie_clr_i   (ie_clr_i),
  .irq_ret_i  (irq_ret_i),
  .ld_en_i    (ld_en_i),
  .ld_val_i   (ld_val_i),
  .irq_pend_i (irq_pend_i),
  .sreg_o     (sreg_o),
  .irq_take_o (irq_take_o)
);

// File: tb/status_reg_gate_test.sv
`timescale 1ns/1ps
module status_reg_gate_test;
  localparam time CYC = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] alu_we = '0, alu_val = '0, ld_val = '0;
  logic       ie_set = 1'b0, ie_clr = 1'b0, irq_ret = 1'b0, ld_en = 1'b0, pend = 1'b0;
  logic [7:0] sreg;
  logic       take;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CYC/2) clk = ~clk;

  status_reg_gate uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .alu_we_i   (alu_we),
    .alu_val_i  (alu_val),
    .ie_set_i   (ie_set),
    .ie_clr_i   (ie_clr),
    .irq_ret_i  (irq_ret),
    .ld_en_i    (ld_en),
    .ld_val_i   (ld_val),
    .irq_pend_i (pend),
    .sreg_o     (sreg),
    .irq_take_o (take)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // flags per R2/R3/R4: I=7 T=6 H=5 S=4 V=3 N=2 Z=1 C=0
  function automatic logic [7:0] arith_model(input logic [7:0] old, input logic [7:0] we,
                                             input logic [7:0] val);
    logic [7:0] r;
    r = old;
    for (int b = 0; b < 8; b++)
      if (b != 7 && b != 4 && we[b]) r[b] = val[b];
    if (we[3] || we[2]) r[4] = r[3] ^ r[2];
    return r;
  endfunction

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] base, exp_s, v;
    logic       i0, p, st, cl, rt, ld, ldi, exp_take, exp_i;

    // R1: reset state, pending held high
    pend = 1'b1;
    #(CYC*2 + 1ns);
    check("R1 sreg in reset", sreg, 8'h00);
    check("R1 take in reset", {7'd0, take}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #2ns;
    check("R1 take after reset", {7'd0, take}, 8'h00);
    @(negedge clk);
    check("R1 sreg after reset", sreg, 8'h00);
    pend = 1'b0;

    // flag sweep: every enable mask, including ignored bits 7 and 4
    for (int e = 0; e < 256; e++) begin
      for (int k = 0; k < 16; k++) begin
        v    = 8'((k * 53 + e * 7) & 255);
        base = 8'((e * 29 + k * 101 + 3) & 255);
        @(negedge clk);
        ld_en = 1'b1; ld_val = base; alu_we = '0;
        @(negedge clk);
        ld_en = 1'b0;
        check("R9 load", sreg, base);
        alu_we = 8'(e); alu_val = v;
        @(negedge clk);
        exp_s = arith_model(base, 8'(e), v);
        check("R2 flags", sreg, exp_s);
        check("R3 sign", {7'd0, sreg[4]}, {7'd0, exp_s[4]});
        check("R4 ie untouched", {7'd0, sreg[7]}, {7'd0, base[7]});
        alu_we = '0;
      end
    end

    // interrupt sweep: all 128 command combinations, ALU writing all flags
    for (int c = 0; c < 128; c++) begin
      i0 = c[0]; p = c[1]; st = c[2]; cl = c[3]; rt = c[4]; ld = c[5]; ldi = c[6];
      base = {i0, 7'(c * 19 + 5)};
      @(negedge clk);
      ld_en = 1'b1; ld_val = base; pend = 1'b0;
      @(negedge clk);
      check("R9 load before combo", sreg, base);
      pend = p; ie_set = st; ie_clr = cl; irq_ret = rt; ld_en = ld;
      ld_val = {ldi, ~base[6:0]};
      alu_we = 8'hFF; alu_val = ~base;
      #2ns;
      exp_take = p & i0 & ~cl;
      check(cl ? "R6 clr blocks take" : "R5 take gate", {7'd0, take}, {7'd0, exp_take});
      if (ld)                 exp_i = ldi;
      else if (exp_take)      exp_i = 1'b0;
      else if (cl)            exp_i = 1'b0;
      else if (st || rt)      exp_i = 1'b1;
      else                    exp_i = i0;
      if (ld) exp_s = {ldi, ~base[6:0]};
      else    exp_s = {exp_i, arith_model(base, 8'hFF, ~base)[6:0]};
      @(negedge clk);
      check(ld ? "R9 load override" : (exp_take ? "R8 take clears" :
            (cl ? "R6 clr clears" : "R7 set/ret")), sreg, exp_s);
      check("R4 ie vs alu", {7'd0, sreg[7]}, {7'd0, exp_i});
      ie_set = 1'b0; ie_clr = 1'b0; irq_ret = 1'b0; ld_en = 1'b0; alu_we = '0;
      #2ns;
      check("R7 pending taken after set", {7'd0, take}, {7'd0, p & exp_i});
    end
    pend = 1'b0;

    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule